// File: doc/BRIEF.md
# Stack and Interrupt Cycle Sequencer

This block runs the bus cycles of every operation on an 8-bit processor that touches the stack: the software break, hardware interrupt entry (maskable and non-maskable), return from interrupt, return from subroutine, subroutine call, and the four single-byte push and pull operations. Each cycle it presents a 16-bit address and a read/write strobe, and it updates the 8-bit stack pointer and the 16-bit program counter. It includes the discarded reads that the processor performs on the bus: the read of the byte after the opcode, and the stack read that comes before each group of pulls.

The surrounding core requests an operation with a one-cycle strobe while the sequencer is idle. The sequencer then runs a fixed number of cycles and returns to idle. During that time it reads memory through `rd_data`. It writes the accumulator or the status register through write-enable outputs and takes their current values from `acc_in` and `stat_in`. A pending hardware interrupt starts its own entry sequence from idle. A non-maskable request that arrives early in a software break takes over that break's vector fetch.

Top module: `stack_irq_sequencer`

## Requirements
- R1: Out of reset S is 0xFD, PC is 0x0400 and `busy` is low. While idle the bus reads at PC. An operation strobed in an idle cycle (`op_sel` 0 break, 1 return-from-interrupt, 2 return-from-subroutine, 3 call, 4 push A, 5 push P, 6 pull A, 7 pull P) begins its first cycle on the next clock. That first cycle reads at PC and increments PC.
- R2: Every stack access uses address 0x0100 + S. Every write is a push, and S is decremented after the write cycle.
- R3: A pull sequence first reads 0x0100 + S as a discard and increments S. Each pulled byte is then read at the incremented S.
- R4: Break takes 7 cycles: read at PC; read at PC+1; push PC+2 high byte; push its low byte; push P with bit 4 and bit 5 forced to 1; read 0xFFFE; read 0xFFFF. The new PC is {byte at 0xFFFF, byte at 0xFFFE}. `stat_we` pulses with `stat_in` with bit 2 set.
- R5: A high `irq_req` starts an entry sequence from idle only when `stat_in` bit 2 is 0. That sequence does not increment PC. It pushes PC high byte, PC low byte, and P with bit 4 cleared and bit 5 set. It then reads 0xFFFE and 0xFFFF, and it sets bit 2 through `stat_we`.
- R6: A rising edge on `nmi_req` is latched until it is served. When the vector is chosen, a latched request wins over the maskable line. Its entry reads 0xFFFA and 0xFFFB and makes no status write.
- R7: A non-maskable edge that arrives no later than the low-byte push of a break redirects that break to 0xFFFA/0xFFFB. The pushed P still has bit 4 set.
- R8: Return-from-interrupt takes 6 cycles: two reads at PC and PC+1, a discarded stack read, and then pulls of P, PC low byte and PC high byte. The pulled P goes out on `stat_we` with bit 5 forced to 1.
- R9: Return-from-subroutine takes 6 cycles. It pulls the PC low byte and then the high byte, and its last cycle reads at the pulled address, leaving PC at that address plus one.
- R10: Call takes 6 cycles. It reads the target low byte at PC+1 and performs a stack read that changes nothing. It then pushes the high byte and then the low byte of PC+2, and last it reads the target high byte at PC+2. PC becomes the target.
- R11: Push A and push P take 3 cycles. Push P writes `stat_in` with bits 4 and 5 forced to 1.
- R12: Pull A and pull P take 4 cycles. The pulled byte goes out on `acc_we`, or on `stat_we` with bit 5 forced to 1, in the fourth cycle.
- R13: When an interrupt is pending in the idle cycle that carries an operation strobe, the interrupt entry runs and the strobed operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation request, sampled while idle |
| op_sel | input | 3 | Operation code, see R1 |
| rd_data | input | 8 | Data read from the bus this cycle |
| acc_in | input | 8 | Current accumulator value |
| stat_in | input | 8 | Current status byte (bit 2 is the interrupt mask) |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| irq_req | input | 1 | Maskable request, level sensitive |
| bus_addr | output | 16 | Address of this cycle |
| bus_rw | output | 1 | 1 for read, 0 for write |
| bus_wdata | output | 8 | Write data of this cycle |
| sp | output | 8 | Stack pointer |
| pc | output | 16 | Program counter |
| busy | output | 1 | High while a sequence runs |
| acc_we | output | 1 | Accumulator load strobe |
| acc_wdata | output | 8 | Accumulator load value |
| stat_we | output | 1 | Status load strobe |
| stat_wdata | output | 8 | Status load value |

## Verification
The bench uses the default parameters: stack page 0x01, vectors 0xFFFA and 0xFFFE, S starting at 0xFD and PC at 0x0400. With these values every expected address is a known constant or a sum near the top of the stack page. The bench memory is a fixed function of the address, so return addresses, pulled bytes and vector targets can all be predicted from the address alone. These settings cover both vector addresses and both interrupt arrival windows, early enough to take over a break and while idle.

// File: rtl/stk_seq_pkg.sv
// Shared types for the stack and interrupt sequencer.
// Assumes an 8-bit status byte with the mask in bit 2, break in bit 4
// and the constant-one bit in bit 5.
package stk_seq_pkg;

    typedef enum logic [3:0] {
        OP_BRK  = 4'd0,
        OP_RTI  = 4'd1,
        OP_RTS  = 4'd2,
        OP_JSR  = 4'd3,
        OP_PHA  = 4'd4,
        OP_PHP  = 4'd5,
        OP_PLA  = 4'd6,
        OP_PLP  = 4'd7,
        OP_INT  = 4'd8,
        OP_NONE = 4'd15
    } seq_op_e;

    typedef enum logic [1:0] {
        AS_PC  = 2'd0,
        AS_STK = 2'd1,
        AS_VLO = 2'd2,
        AS_VHI = 2'd3
    } addr_src_e;

    typedef enum logic [1:0] {
        WS_PCH  = 2'd0,
        WS_PCL  = 2'd1,
        WS_STAT = 2'd2,
        WS_ACC  = 2'd3
    } wr_src_e;

    // One cycle's worth of control
    typedef struct packed {
        logic      rd;
        addr_src_e asrc;
        wr_src_e   wsrc;
        logic      pc_inc;
        logic      s_inc;
        logic      s_dec;
        logic      ld_tmp;
        logic      ld_pc;
        logic      acc_we;
        logic      stat_pull;
        logic      stat_seti;
        logic      pick_vec;
        logic      last;
    } uop_t;

    localparam int ST_I = 2;
    localparam int ST_B = 4;
    localparam int ST_U = 5;

endpackage

// File: rtl/stk_irq_arb.sv
// Interrupt request arbiter.
// Latches rising edges of the non-maskable line until a vector choice
// consumes them; qualifies the level-sensitive line with the mask bit.
// Assumes requests are already synchronous to clk.
module stk_irq_arb
    import stk_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              take_vec,
    output logic              nmi_hit,
    output logic              int_pend
);

    logic nmi_q;
    logic nmi_pend;
    logic nmi_edge;

    assign nmi_edge = nmi_req & ~nmi_q;
    assign nmi_hit  = nmi_pend | nmi_edge;
    assign int_pend = nmi_hit | (irq_req & ~stat_in[ST_I]);

    // Remember the previous level of the non-maskable line
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_req;
    end

    // Hold a seen edge until the vector choice takes it
    always_ff @(posedge clk) begin
        if (!rst_n)                   nmi_pend <= 1'b0;
        else if (take_vec && nmi_hit) nmi_pend <= 1'b0;
        else if (nmi_edge)            nmi_pend <= 1'b1;
    end

    // R6: a served request does not linger
    assert_nmi_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vec && nmi_hit) |=> !nmi_pend);

endmodule

// File: rtl/stk_seq_ctl.sv
// Sequence controller.
// Holds the running operation and its cycle number, starts interrupt
// entry or a requested operation from idle, and decodes the control for
// the current cycle. Assumes op_valid is only meaningful while idle.
module stk_seq_ctl
    import stk_seq_pkg::*;
#(
    parameter int MAX_CYC = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [2:0] op_sel,
    input  logic       int_pend,
    input  logic       nmi_hit,
    output uop_t       uop,
    output logic       busy,
    output logic       is_int,
    output logic       vec_nmi,
    output logic       take_vec
);

    localparam int CYC_W = $clog2(MAX_CYC + 1);

    seq_op_e          op_q;
    logic [CYC_W-1:0] cyc;

    assign busy     = (cyc != '0);
    assign is_int   = (op_q == OP_INT);
    assign take_vec = busy & uop.pick_vec;

    // Decode the control word for the operation and cycle in progress
    always_comb begin
        uop        = '0;
        uop.rd     = 1'b1;
        uop.asrc   = AS_PC;
        uop.wsrc   = WS_PCH;
        if (busy) begin
            if (cyc == CYC_W'(1) && op_q != OP_INT) uop.pc_inc = 1'b1;
            case (op_q)
                OP_BRK, OP_INT: begin
                    case (cyc)
                        CYC_W'(2): uop.pc_inc = (op_q == OP_BRK);
                        CYC_W'(3): begin
                            uop.rd = 1'b0; uop.asrc = AS_STK;
                            uop.wsrc = WS_PCH; uop.s_dec = 1'b1;
                        end
                        CYC_W'(4): begin
                            uop.rd = 1'b0; uop.asrc = AS_STK;
                            uop.wsrc = WS_PCL; uop.s_dec = 1'b1;
                            uop.pick_vec = 1'b1;
                        end
                        CYC_W'(5): begin
                            uop.rd = 1'b0; uop.asrc = AS_STK;
                            uop.wsrc = WS_STAT; uop.s_dec = 1'b1;
                        end
                        CYC_W'(6): begin
                            uop.asrc = AS_VLO; uop.ld_tmp = 1'b1;
                        end
                        CYC_W'(7): begin
                            uop.asrc = AS_VHI; uop.ld_pc = 1'b1;
                            uop.stat_seti = 1'b1; uop.last = 1'b1;
                        end
                        default: ;
                    endcase
                end
                OP_RTI: begin
                    case (cyc)
                        CYC_W'(3): begin uop.asrc = AS_STK; uop.s_inc = 1'b1; end
                        CYC_W'(4): begin
                            uop.asrc = AS_STK; uop.s_inc = 1'b1; uop.stat_pull = 1'b1;
                        end
                        CYC_W'(5): begin
                            uop.asrc = AS_STK; uop.s_inc = 1'b1; uop.ld_tmp = 1'b1;
                        end
                        CYC_W'(6): begin
                            uop.asrc = AS_STK; uop.ld_pc = 1'b1; uop.last = 1'b1;
                        end
                        default: ;
                    endcase
                end
                OP_RTS: begin
                    case (cyc)
                        CYC_W'(3): begin uop.asrc = AS_STK; uop.s_inc = 1'b1; end
                        CYC_W'(4): begin
                            uop.asrc = AS_STK; uop.s_inc = 1'b1; uop.ld_tmp = 1'b1;
                        end
                        CYC_W'(5): begin uop.asrc = AS_STK; uop.ld_pc = 1'b1; end
                        CYC_W'(6): begin uop.pc_inc = 1'b1; uop.last = 1'b1; end
                        default: ;
                    endcase
                end
                OP_JSR: begin
                    case (cyc)
                        CYC_W'(2): begin uop.ld_tmp = 1'b1; uop.pc_inc = 1'b1; end
                        CYC_W'(3): uop.asrc = AS_STK;
                        CYC_W'(4): begin
                            uop.rd = 1'b0; uop.asrc = AS_STK;
                            uop.wsrc = WS_PCH; uop.s_dec = 1'b1;
                        end
                        CYC_W'(5): begin
                            uop.rd = 1'b0; uop.asrc = AS_STK;
                            uop.wsrc = WS_PCL; uop.s_dec = 1'b1;
                        end
                        CYC_W'(6): begin uop.ld_pc = 1'b1; uop.last = 1'b1; end
                        default: ;
                    endcase
                end
                OP_PHA, OP_PHP: begin
                    if (cyc == CYC_W'(3)) begin
                        uop.rd   = 1'b0;
                        uop.asrc = AS_STK;
                        uop.wsrc = (op_q == OP_PHA) ? WS_ACC : WS_STAT;
                        uop.s_dec = 1'b1;
                        uop.last = 1'b1;
                    end
                end
                OP_PLA, OP_PLP: begin
                    case (cyc)
                        CYC_W'(3): begin uop.asrc = AS_STK; uop.s_inc = 1'b1; end
                        CYC_W'(4): begin
                            uop.asrc      = AS_STK;
                            uop.acc_we    = (op_q == OP_PLA);
                            uop.stat_pull = (op_q == OP_PLP);
                            uop.last      = 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: uop.last = 1'b1;
            endcase
        end
    end

    // Start, advance and finish sequences
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_NONE;
            cyc  <= '0;
        end else if (!busy) begin
            if (int_pend) begin
                op_q <= OP_INT;
                cyc  <= CYC_W'(1);
            end else if (op_valid) begin
                op_q <= seq_op_e'({1'b0, op_sel});
                cyc  <= CYC_W'(1);
            end
        end else if (uop.last) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + CYC_W'(1);
        end
    end

    // Freeze the vector choice at the low-byte push
    always_ff @(posedge clk) begin
        if (!rst_n)        vec_nmi <= 1'b0;
        else if (take_vec) vec_nmi <= nmi_hit;
    end

    // R13: a pending interrupt always wins an idle cycle
    assert_int_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && int_pend) |=> (busy && op_q == OP_INT));

endmodule

// File: rtl/stk_datapath.sv
// Address, data and register datapath.
// Owns S, PC and the byte holding register; forms the bus address,
// write data and the accumulator and status load values from the
// control word. Assumes an 8-bit data path and 16-bit addresses.
module stk_datapath
    import stk_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STACK_PAGE = 'h01,
    parameter int NMI_VEC    = 'hFFFA,
    parameter int IRQ_VEC    = 'hFFFE,
    parameter int SP_INIT    = 'hFD,
    parameter int PC_INIT    = 'h0400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  uop_t                uop,
    input  logic                busy,
    input  logic                is_int,
    input  logic                vec_nmi,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   stat_in,
    output logic [2*DATA_W-1:0] bus_addr,
    output logic                bus_rw,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   sp,
    output logic [2*DATA_W-1:0] pc,
    output logic                acc_we,
    output logic [DATA_W-1:0]   acc_wdata,
    output logic                stat_we,
    output logic [DATA_W-1:0]   stat_wdata
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] PAGE   = DATA_W'(STACK_PAGE);
    localparam logic [ADDR_W-1:0] NMI_LO = ADDR_W'(NMI_VEC);
    localparam logic [ADDR_W-1:0] NMI_HI = ADDR_W'(NMI_VEC + 1);
    localparam logic [ADDR_W-1:0] IRQ_LO = ADDR_W'(IRQ_VEC);
    localparam logic [ADDR_W-1:0] IRQ_HI = ADDR_W'(IRQ_VEC + 1);

    logic [DATA_W-1:0] tmp;
    logic [DATA_W-1:0] push_stat;

    // Stack pointer: post-decrement on push, step up on pull
    always_ff @(posedge clk) begin
        if (!rst_n)         sp <= DATA_W'(SP_INIT);
        else if (uop.s_inc) sp <= sp + DATA_W'(1);
        else if (uop.s_dec) sp <= sp - DATA_W'(1);
    end

    // Program counter: load from fetched bytes or step forward
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= ADDR_W'(PC_INIT);
        else if (uop.ld_pc)  pc <= {rd_data, tmp};
        else if (uop.pc_inc) pc <= pc + ADDR_W'(1);
    end

    // Holding register for a fetched low byte
    always_ff @(posedge clk) begin
        if (!rst_n)         tmp <= '0;
        else if (uop.ld_tmp) tmp <= rd_data;
    end

    // Status byte as pushed: constant bit set, break bit by origin
    always_comb begin
        push_stat       = stat_in;
        push_stat[ST_U] = 1'b1;
        push_stat[ST_B] = ~is_int;
    end

    // Bus address for this cycle
    always_comb begin
        case (uop.asrc)
            AS_STK:  bus_addr = {PAGE, sp};
            AS_VLO:  bus_addr = vec_nmi ? NMI_LO : IRQ_LO;
            AS_VHI:  bus_addr = vec_nmi ? NMI_HI : IRQ_HI;
            default: bus_addr = pc;
        endcase
    end

    // Write data for this cycle
    always_comb begin
        case (uop.wsrc)
            WS_PCL:  bus_wdata = pc[DATA_W-1:0];
            WS_STAT: bus_wdata = push_stat;
            WS_ACC:  bus_wdata = acc_in;
            default: bus_wdata = pc[ADDR_W-1:DATA_W];
        endcase
    end

    assign bus_rw    = uop.rd;
    assign acc_we    = uop.acc_we;
    assign acc_wdata = rd_data;

    // Status loads: pulled byte, or mask set on a maskable vector
    always_comb begin
        stat_we    = 1'b0;
        stat_wdata = stat_in;
        if (uop.stat_pull) begin
            stat_we          = 1'b1;
            stat_wdata       = rd_data;
            stat_wdata[ST_U] = 1'b1;
        end else if (uop.stat_seti && !vec_nmi) begin
            stat_we          = 1'b1;
            stat_wdata[ST_I] = 1'b1;
        end
    end

    // R2: writes stay inside the stack page
    assert_push_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw |-> bus_addr[ADDR_W-1:DATA_W] == PAGE);

    // R2: each write is followed by one step down of S
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw |=> sp == $past(sp) - DATA_W'(1));

    // R4: vector low byte read is followed by the high byte read
    assert_vec_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && uop.asrc == AS_VLO) |=> bus_addr == $past(bus_addr) + ADDR_W'(1));

endmodule

// File: rtl/stack_irq_sequencer.sv
// Top of the stack and interrupt cycle sequencer.
// Connects the request arbiter, the sequence controller and the
// datapath. Assumes the core only strobes op_valid while busy is low.
module stack_irq_sequencer
    import stk_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STACK_PAGE = 'h01,
    parameter int NMI_VEC    = 'hFFFA,
    parameter int IRQ_VEC    = 'hFFFE,
    parameter int SP_INIT    = 'hFD,
    parameter int PC_INIT    = 'h0400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_sel,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   stat_in,
    input  logic                nmi_req,
    input  logic                irq_req,
    output logic [2*DATA_W-1:0] bus_addr,
    output logic                bus_rw,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   sp,
    output logic [2*DATA_W-1:0] pc,
    output logic                busy,
    output logic                acc_we,
    output logic [DATA_W-1:0]   acc_wdata,
    output logic                stat_we,
    output logic [DATA_W-1:0]   stat_wdata
);

    uop_t uop;
    logic is_int;
    logic vec_nmi;
    logic take_vec;
    logic nmi_hit;
    logic int_pend;

    stk_irq_arb #(.DATA_W(DATA_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .stat_in  (stat_in),
        .take_vec (take_vec),
        .nmi_hit  (nmi_hit),
        .int_pend (int_pend)
    );

    stk_seq_ctl #(.MAX_CYC(7)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .int_pend (int_pend),
        .nmi_hit  (nmi_hit),
        .uop      (uop),
        .busy     (busy),
        .is_int   (is_int),
        .vec_nmi  (vec_nmi),
        .take_vec (take_vec)
    );

    stk_datapath #(
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE),
        .NMI_VEC    (NMI_VEC),
        .IRQ_VEC    (IRQ_VEC),
        .SP_INIT    (SP_INIT),
        .PC_INIT    (PC_INIT)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .uop        (uop),
        .busy       (busy),
        .is_int     (is_int),
        .vec_nmi    (vec_nmi),
        .rd_data    (rd_data),
        .acc_in     (acc_in),
        .stat_in    (stat_in),
        .bus_addr   (bus_addr),
        .bus_rw     (bus_rw),
        .bus_wdata  (bus_wdata),
        .sp         (sp),
        .pc         (pc),
        .acc_we     (acc_we),
        .acc_wdata  (acc_wdata),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata)
    );

endmodule

// File: tb/stack_irq_sequencer_tb.sv
// Scoreboard bench: tasks queue the expected bus cycles, a monitor
// compares them cycle by cycle while the sequencer is busy.
module stack_irq_sequencer_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [7:0]  rd_data;
    logic [7:0]  acc_in = 8'hA5;
    logic [7:0]  stat_in = 8'h80;
    logic        nmi_req = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] bus_addr;
    logic        bus_rw;
    logic [7:0]  bus_wdata;
    logic [7:0]  sp;
    logic [15:0] pc;
    logic        busy;
    logic        acc_we;
    logic [7:0]  acc_wdata;
    logic        stat_we;
    logic [7:0]  stat_wdata;

    always #(CLK_P/2) clk = ~clk;

    stack_irq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .rd_data(rd_data), .acc_in(acc_in), .stat_in(stat_in),
        .nmi_req(nmi_req), .irq_req(irq_req), .bus_addr(bus_addr),
        .bus_rw(bus_rw), .bus_wdata(bus_wdata), .sp(sp), .pc(pc),
        .busy(busy), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata)
    );

    // Memory content is a fixed function of the address
    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction
    assign rd_data = mem_at(bus_addr);

    typedef struct {
        logic [15:0] a;
        logic        rw;
        logic [7:0]  wd;
        logic [7:0]  s;
        string       rq;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int st_cnt = 0;
    logic [7:0] st_val = '0;
    int ac_cnt = 0;
    logic [7:0] ac_val = '0;
    bit finished = 0;

    logic [7:0]  m_s;
    logic [15:0] m_pc;

    task automatic exp(input logic [15:0] a, input logic rw,
                       input logic [7:0] wd, input logic [7:0] s, input string rq);
        exp_t e;
        e.a = a; e.rw = rw; e.wd = wd; e.s = s; e.rq = rq;
        q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string rq,
                       input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    // Monitor: compare each busy cycle with the queued expectation
    always @(negedge clk) begin
        if (rst_n && busy) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected busy cycle actual=%h expected=idle", bus_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (bus_addr !== e.a || bus_rw !== e.rw || sp !== e.s ||
                    (!e.rw && bus_wdata !== e.wd)) begin
                    errors++;
                    $display("FAIL %s actual addr=%h rw=%b wd=%h s=%h expected addr=%h rw=%b wd=%h s=%h",
                             e.rq, bus_addr, bus_rw, bus_wdata, sp, e.a, e.rw, e.wd, e.s);
                end
            end
        end
        if (rst_n && stat_we) begin st_cnt++; st_val = stat_wdata; end
        if (rst_n && acc_we)  begin ac_cnt++; ac_val = acc_wdata;  end
    end

    task automatic strobe(input logic [2:0] op);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_idle(input string rq);
        while (busy) @(negedge clk);
        chk(q.size() == 0, rq, 16'(q.size()), 16'd0);
    endtask

    // Expected entry sequence; brk selects break origin, nmi the vector
    task automatic exp_entry(input bit brk, input bit nmi, input string rq);
        logic [15:0] ret;
        logic [15:0] vl;
        logic [7:0]  ps;
        ret = brk ? m_pc + 16'd2 : m_pc;
        vl  = nmi ? 16'hFFFA : 16'hFFFE;
        ps  = stat_in | 8'h20;
        ps[4] = brk;
        exp(m_pc, 1, 0, m_s, rq);
        exp(brk ? m_pc + 16'd1 : m_pc, 1, 0, m_s, rq);
        exp({8'h01, m_s}, 0, ret[15:8], m_s, rq);
        exp({8'h01, m_s - 8'd1}, 0, ret[7:0], m_s - 8'd1, rq);
        exp({8'h01, m_s - 8'd2}, 0, ps, m_s - 8'd2, rq);
        exp(vl, 1, 0, m_s - 8'd3, rq);
        exp(vl + 16'd1, 1, 0, m_s - 8'd3, rq);
        m_s  = m_s - 8'd3;
        m_pc = {mem_at(vl + 16'd1), mem_at(vl)};
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  b0, b1;
        logic [15:0] t;
        m_s  = 8'hFD;
        m_pc = 16'h0400;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and idle bus
        chk(sp == 8'hFD, "R1 reset S", 16'(sp), 16'h00FD);
        chk(pc == 16'h0400, "R1 reset PC", pc, 16'h0400);
        chk(!busy && bus_rw && bus_addr == pc, "R1 idle read at PC", bus_addr, pc);

        // R11 push A
        exp(m_pc, 1, 0, m_s, "R11 pha");
        exp(m_pc + 16'd1, 1, 0, m_s, "R11 pha");
        exp({8'h01, m_s}, 0, 8'hA5, m_s, "R11 pha");
        m_pc++; m_s--;
        strobe(3'd4); wait_idle("R11 pha");
        chk(pc == m_pc && sp == m_s, "R11 pha PC", pc, m_pc);

        // R11 push P forces bits 4 and 5
        stat_in = 8'hC3;
        exp(m_pc, 1, 0, m_s, "R11 php");
        exp(m_pc + 16'd1, 1, 0, m_s, "R11 php");
        exp({8'h01, m_s}, 0, 8'hF3, m_s, "R11 php");
        m_pc++; m_s--;
        strobe(3'd5); wait_idle("R11 php");

        // R12 and R3 pull A
        exp(m_pc, 1, 0, m_s, "R12 pla");
        exp(m_pc + 16'd1, 1, 0, m_s, "R12 pla");
        exp({8'h01, m_s}, 1, 0, m_s, "R3 pla discard");
        exp({8'h01, m_s + 8'd1}, 1, 0, m_s + 8'd1, "R12 pla");
        b0 = mem_at({8'h01, m_s + 8'd1});
        m_pc++; m_s++;
        strobe(3'd6); wait_idle("R12 pla");
        chk(ac_cnt == 1 && ac_val == b0, "R12 pla value", 16'(ac_val), 16'(b0));

        // R12 pull P forces bit 5
        exp(m_pc, 1, 0, m_s, "R12 plp");
        exp(m_pc + 16'd1, 1, 0, m_s, "R12 plp");
        exp({8'h01, m_s}, 1, 0, m_s, "R3 plp discard");
        exp({8'h01, m_s + 8'd1}, 1, 0, m_s + 8'd1, "R12 plp");
        b0 = mem_at({8'h01, m_s + 8'd1}) | 8'h20;
        m_pc++; m_s++;
        strobe(3'd7); wait_idle("R12 plp");
        chk(st_cnt == 1 && st_val == b0, "R12 plp value", 16'(st_val), 16'(b0));

        // R10 call
        stat_in = 8'h80;
        b0 = mem_at(m_pc + 16'd1);
        b1 = mem_at(m_pc + 16'd2);
        t  = m_pc + 16'd2;
        exp(m_pc, 1, 0, m_s, "R10 jsr");
        exp(m_pc + 16'd1, 1, 0, m_s, "R10 jsr");
        exp({8'h01, m_s}, 1, 0, m_s, "R10 jsr stack read");
        exp({8'h01, m_s}, 0, t[15:8], m_s, "R10 jsr push high");
        exp({8'h01, m_s - 8'd1}, 0, t[7:0], m_s - 8'd1, "R10 jsr push low");
        exp(t, 1, 0, m_s - 8'd2, "R10 jsr target high");
        m_pc = {b1, b0}; m_s = m_s - 8'd2;
        strobe(3'd3); wait_idle("R10 jsr");
        chk(pc == m_pc && sp == m_s, "R10 jsr PC", pc, m_pc);

        // R9 return from subroutine
        b0 = mem_at({8'h01, m_s + 8'd1});
        b1 = mem_at({8'h01, m_s + 8'd2});
        exp(m_pc, 1, 0, m_s, "R9 rts");
        exp(m_pc + 16'd1, 1, 0, m_s, "R9 rts");
        exp({8'h01, m_s}, 1, 0, m_s, "R3 rts discard");
        exp({8'h01, m_s + 8'd1}, 1, 0, m_s + 8'd1, "R9 rts low");
        exp({8'h01, m_s + 8'd2}, 1, 0, m_s + 8'd2, "R9 rts high");
        exp({b1, b0}, 1, 0, m_s + 8'd2, "R9 rts final read");
        m_pc = {b1, b0} + 16'd1; m_s = m_s + 8'd2;
        strobe(3'd2); wait_idle("R9 rts");
        chk(pc == m_pc, "R9 rts PC", pc, m_pc);

        // R8 return from interrupt
        st_cnt = 0;
        b0 = mem_at({8'h01, m_s + 8'd2});
        b1 = mem_at({8'h01, m_s + 8'd3});
        t  = 16'(mem_at({8'h01, m_s + 8'd1}) | 8'h20);
        exp(m_pc, 1, 0, m_s, "R8 rti");
        exp(m_pc + 16'd1, 1, 0, m_s, "R8 rti");
        exp({8'h01, m_s}, 1, 0, m_s, "R3 rti discard");
        exp({8'h01, m_s + 8'd1}, 1, 0, m_s + 8'd1, "R8 rti P");
        exp({8'h01, m_s + 8'd2}, 1, 0, m_s + 8'd2, "R8 rti low");
        exp({8'h01, m_s + 8'd3}, 1, 0, m_s + 8'd3, "R8 rti high");
        m_pc = {b1, b0}; m_s = m_s + 8'd3;
        strobe(3'd1); wait_idle("R8 rti");
        chk(pc == m_pc, "R8 rti PC", pc, m_pc);
        chk(st_cnt == 1 && 16'(st_val) == t, "R8 rti P value", 16'(st_val), t);

        // R4 break with no interrupt pending
        st_cnt = 0;
        exp_entry(1, 0, "R4 brk");
        strobe(3'd0); wait_idle("R4 brk");
        chk(pc == m_pc, "R4 brk vector PC", pc, m_pc);
        chk(st_cnt == 1 && st_val == 8'h84, "R4 brk sets mask", 16'(st_val), 16'h0084);

        // R5 masked request is ignored while push A runs
        stat_in = 8'h84;
        @(negedge clk);
        irq_req = 1'b1;
        exp(m_pc, 1, 0, m_s, "R5 masked irq ignored");
        exp(m_pc + 16'd1, 1, 0, m_s, "R5 masked irq ignored");
        exp({8'h01, m_s}, 0, 8'hA5, m_s, "R5 masked irq ignored");
        m_pc++; m_s--;
        strobe(3'd4); wait_idle("R5 masked");
        chk(!busy, "R5 masked stays idle", 16'(busy), 16'd0);

        // R5 unmasked entry
        st_cnt  = 0;
        stat_in = 8'h80;
        exp_entry(0, 0, "R5 irq entry");
        @(negedge clk);
        irq_req = 1'b0;
        wait_idle("R5 irq");
        chk(pc == m_pc, "R5 irq vector PC", pc, m_pc);
        chk(st_cnt == 1 && st_val == 8'h84, "R5 irq sets mask", 16'(st_val), 16'h0084);

        // R6 both requests: non-maskable first, then maskable
        st_cnt = 0;
        exp_entry(0, 1, "R6 nmi priority");
        @(negedge clk);
        nmi_req = 1'b1;
        irq_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        while (busy) @(negedge clk);
        chk(q.size() == 0 && pc == m_pc, "R6 nmi vector PC", pc, m_pc);
        chk(st_cnt == 0, "R6 nmi leaves mask", 16'(st_cnt), 16'd0);
        exp_entry(0, 0, "R6 irq after nmi");
        @(negedge clk);
        irq_req = 1'b0;
        wait_idle("R6 irq after nmi");
        chk(pc == m_pc, "R6 second vector PC", pc, m_pc);

        // R13 interrupt wins over a strobed operation
        exp_entry(0, 1, "R13 nmi over op");
        @(negedge clk);
        nmi_req  = 1'b1;
        op_valid = 1'b1;
        op_sel   = 3'd4;
        @(negedge clk);
        op_valid = 1'b0;
        nmi_req  = 1'b0;
        wait_idle("R13 nmi over op");
        @(negedge clk);
        @(negedge clk);
        chk(!busy && sp == m_s, "R13 op dropped", 16'(sp), 16'(m_s));

        // R7 break taken over by a non-maskable edge in its second cycle
        st_cnt = 0;
        exp_entry(1, 1, "R7 brk hijack");
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = 3'd0;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        nmi_req = 1'b1;
        wait_idle("R7 brk hijack");
        nmi_req = 1'b0;
        chk(pc == m_pc, "R7 hijack PC", pc, m_pc);
        chk(st_cnt == 0, "R7 hijack leaves mask", 16'(st_cnt), 16'd0);
        repeat (3) @(negedge clk);
        chk(!busy, "R7 edge consumed once", 16'(busy), 16'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule